// File: doc/BRIEF.md
# Mailbox Message Queue with Packed Status

This block is a small first-in first-out queue for 32-bit mailbox messages. A producer pushes one word per cycle. A consumer pops one word per cycle and receives it on a registered output, together with a one-cycle valid strobe. The oldest entry is always visible on a peek output, and reading it there does not disturb the queue.

Storage is a shift line with the head at slot 0. A pop moves every remaining entry one place toward the head. Each slot that becomes free is rewritten with a reserved invalid-data marker, so a peek of an empty queue gives a known value and never stale data.

A 32-bit status word carries the full and empty flags in fixed bit positions for a neighbouring register decoder. A synchronous clear empties the queue in a single cycle. Requests the queue cannot honour are dropped, and each one is reported on its own one-cycle strobe.

Top module: `mbox_msg_queue`

## Requirements
- R1: After reset the count is 0, `status` reads 32'h4000_0000, `peek_data` reads 32'hFFFF_FFFF, and `overflow`, `underflow` and `pop_valid` are low.
- R2: `status` bit 31 is high exactly when the count equals DEPTH (default 8). Bit 30 is high exactly when the count is 0. Bits 29..0 are always 0. `full` and `empty` equal bits 31 and 30.
- R3: An accepted push appends `push_data` at the tail. An accepted pop presents the oldest entry on `pop_data` with `pop_valid` high in the cycle after the request, so words leave in push order.
- R4: `peek_data` always shows the oldest entry. A cycle with no push, no pop and no clear leaves `peek_data` and `count` unchanged.
- R5: Every slot vacated by a pop or a clear holds the marker 32'hFFFF_FFFF, so `peek_data` equals the marker whenever the queue is empty.
- R6: A push made while the count equals DEPTH at the start of the cycle is dropped, even if a pop is accepted in the same cycle. `overflow` is high for exactly the following cycle.
- R7: A pop made while the queue is empty is dropped. `underflow` is high for the following cycle and `pop_valid` stays low. A push in the same cycle is still accepted.
- R8: A push and a pop in the same cycle, with the queue neither full nor empty, leave the count unchanged and keep push order.
- R9: `clear` is synchronous and overrides push and pop. In the next cycle the count is 0, `peek_data` is the marker, and the strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of the whole queue |
| push_req | input | 1 | Push request |
| push_data | input | 32 | Word to push |
| pop_req | input | 1 | Pop request |
| pop_data | output | 32 | Last popped word, registered |
| pop_valid | output | 1 | `pop_data` was updated by the previous request |
| peek_data | output | 32 | Oldest entry, or the marker when empty |
| count | output | 4 | Number of valid entries |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entries |
| status | output | 32 | Packed status: bit 31 full, bit 30 empty, others 0 |
| overflow | output | 1 | One-cycle strobe for a dropped push |
| underflow | output | 1 | One-cycle strobe for a dropped pop |

## Verification
A wrong count shows up in the same cycle on `status`, `full` and `empty`. A slot that holds the wrong word, or one never refilled with the marker, reaches `peek_data` once the pops ahead of it have drained. That takes at most DEPTH cycles, or one cycle if the fault is at the head. A mis-ordered shift shows on `pop_data` one cycle after the pop that exposes it. Comparing every output on every clock against a behavioural queue catches each of these at the first cycle it becomes visible.

// File: rtl/mbq_pkg.sv
package mbq_pkg;
   localparam int unsigned STATUS_W    = 32;
   localparam int unsigned FULL_BIT    = 31;
   localparam int unsigned EMPTY_BIT   = 30;

   function automatic logic [STATUS_W-1:0] mbq_pack_status(input logic is_full,
                                                           input logic is_empty);
      logic [STATUS_W-1:0] w;
      w            = '0;
      w[FULL_BIT]  = is_full;
      w[EMPTY_BIT] = is_empty;
      return w;
   endfunction
endpackage

// File: rtl/mbq_status.sv
module mbq_status
   import mbq_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned CNT_W = 4
) (
   input  logic [CNT_W-1:0]    count,
   output logic                full,
   output logic                empty,
   output logic [STATUS_W-1:0] status
);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   assign full   = (count == DEPTH_C);
   assign empty  = (count == '0);
   assign status = mbq_pack_status(full, empty);
endmodule

// File: rtl/mbq_ctrl.sv
module mbq_ctrl #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             push_req,
   input  logic             pop_req,
   input  logic             full,
   input  logic             empty,
   output logic             push_acc,
   output logic             pop_acc,
   output logic [CNT_W-1:0] count,
   output logic             overflow,
   output logic             underflow,
   output logic             pop_valid
);
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             ovf_q, unf_q, pv_q;

   assign push_acc = !clear && push_req && !full;
   assign pop_acc  = !clear && pop_req && !empty;

   always_comb begin
      cnt_d = cnt_q;
      if (clear) begin
         cnt_d = '0;
      end else begin
         unique case ({push_acc, pop_acc})
            2'b10:   cnt_d = cnt_q + CNT_W'(1);
            2'b01:   cnt_d = cnt_q - CNT_W'(1);
            default: cnt_d = cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
         pv_q  <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         ovf_q <= !clear && push_req && full;
         unf_q <= !clear && pop_req && empty;
         pv_q  <= pop_acc;
      end
   end

   assign count     = cnt_q;
   assign overflow  = ovf_q;
   assign underflow = unf_q;
   assign pop_valid = pv_q;
endmodule

// File: rtl/mbq_store.sv
module mbq_store #(
   parameter int unsigned          DATA_W = 32,
   parameter int unsigned          DEPTH  = 8,
   parameter int unsigned          CNT_W  = 4,
   parameter logic [DATA_W-1:0]    MARKER = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              push_acc,
   input  logic              pop_acc,
   input  logic [CNT_W-1:0]  count,
   input  logic [DATA_W-1:0] push_data,
   output logic [DATA_W-1:0] head
);
   logic [DEPTH-1:0][DATA_W-1:0] slots;
   logic [CNT_W-1:0]             tail_idx;

   // Write position: one lower when the same cycle also shifts the line.
   assign tail_idx = pop_acc ? (count - CNT_W'(1)) : count;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
      logic [DATA_W-1:0] q;
      logic [DATA_W-1:0] shift_in;

      if (i == DEPTH - 1) begin : g_last
         assign shift_in = MARKER;
      end else begin : g_mid
         assign shift_in = slots[i+1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= MARKER;
         end else if (clear) begin
            q <= MARKER;
         end else if (push_acc && (tail_idx == IDX)) begin
            q <= push_data;
         end else if (pop_acc) begin
            q <= shift_in;
         end
      end

      assign slots[i] = q;
   end

   assign head = slots[0];
endmodule

// File: rtl/mbox_msg_queue.sv
module mbox_msg_queue
   import mbq_pkg::*;
#(
   parameter int unsigned       DATA_W = 32,
   parameter int unsigned       DEPTH  = 8,
   parameter logic [DATA_W-1:0] MARKER = '1,
   localparam int unsigned      CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                push_req,
   input  logic [DATA_W-1:0]   push_data,
   input  logic                pop_req,
   output logic [DATA_W-1:0]   pop_data,
   output logic                pop_valid,
   output logic [DATA_W-1:0]   peek_data,
   output logic [CNT_W-1:0]    count,
   output logic                full,
   output logic                empty,
   output logic [STATUS_W-1:0] status,
   output logic                overflow,
   output logic                underflow
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("mbox_msg_queue: DEPTH must be at least 2");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("mbox_msg_queue: DATA_W must be at least 2");
   end

   logic              push_acc, pop_acc;
   logic [DATA_W-1:0] head;
   logic [DATA_W-1:0] pop_q;

   mbq_status #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_status (
      .count  (count),
      .full   (full),
      .empty  (empty),
      .status (status)
   );

   mbq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .push_req  (push_req),
      .pop_req   (pop_req),
      .full      (full),
      .empty     (empty),
      .push_acc  (push_acc),
      .pop_acc   (pop_acc),
      .count     (count),
      .overflow  (overflow),
      .underflow (underflow),
      .pop_valid (pop_valid)
   );

   mbq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .MARKER(MARKER)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .push_acc  (push_acc),
      .pop_acc   (pop_acc),
      .count     (count),
      .push_data (push_data),
      .head      (head)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pop_q <= '0;
      end else if (pop_acc) begin
         pop_q <= head;
      end
   end

   assign pop_data  = pop_q;
   assign peek_data = head;
endmodule

// File: rtl/mbq_checker.sv
module mbq_checker #(
   parameter int unsigned       DATA_W = 32,
   parameter int unsigned       DEPTH  = 8,
   parameter int unsigned       CNT_W  = 4,
   parameter logic [DATA_W-1:0] MARKER = '1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clear,
   input logic              push_req,
   input logic              pop_req,
   input logic              pop_valid,
   input logic [DATA_W-1:0] peek_data,
   input logic [CNT_W-1:0]  count,
   input logic              full,
   input logic              empty,
   input logic [31:0]       status,
   input logic              overflow,
   input logic              underflow
);
   a_r2_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (status[31] == full) && (status[30] == empty) && (status[29:0] == '0)
      && !(full && empty));

   a_r4_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!push_req && !pop_req && !clear) |=> ($stable(peek_data) && $stable(count)));

   a_r5_empty_marker: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (peek_data == MARKER));

   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && full && !pop_req && !clear) |=> (overflow && count == CNT_W'(DEPTH)));

   a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && empty && !clear) |=> (underflow && !pop_valid));

   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (empty && !overflow && !underflow && !pop_valid));
endmodule

bind mbox_msg_queue mbq_checker #(
   .DATA_W (DATA_W),
   .DEPTH  (DEPTH),
   .CNT_W  (CNT_W),
   .MARKER (MARKER)
) u_mbq_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .clear     (clear),
   .push_req  (push_req),
   .pop_req   (pop_req),
   .pop_valid (pop_valid),
   .peek_data (peek_data),
   .count     (count),
   .full      (full),
   .empty     (empty),
   .status    (status),
   .overflow  (overflow),
   .underflow (underflow)
);

// File: tb/test_mbox_msg_queue.sv
`timescale 1ns/1ps
module test_mbox_msg_queue;
   localparam int DEPTH = 8;
   localparam logic [31:0] MARK = 32'hFFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clear = 1'b0;
   logic        push_req = 1'b0;
   logic [31:0] push_data = '0;
   logic        pop_req = 1'b0;
   logic [31:0] pop_data, peek_data, status;
   logic        pop_valid, full, empty, overflow, underflow;
   logic [3:0]  count;

   int tests = 0;
   int fails = 0;
   bit done = 0;

   // Behavioural reference state
   logic [31:0] mq[$];
   bit          e_ov, e_un, e_pv;
   logic [31:0] e_pd;

   always #2 clk = ~clk;

   mbox_msg_queue i_mbox_msg_queue (
      .clk, .rst_n, .clear, .push_req, .push_data, .pop_req,
      .pop_data, .pop_valid, .peek_data, .count, .full, .empty,
      .status, .overflow, .underflow
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      bit fl, em;
      fl = (mq.size() == DEPTH);
      em = (mq.size() == 0);
      chk(tag, "count", 32'(count), 32'(mq.size()));
      chk(tag, "status", status, {fl, em, 30'b0});
      chk(tag, "full/empty", {30'b0, full, empty}, {30'b0, fl, em});
      chk(tag, "peek", peek_data, em ? MARK : mq[0]);
      chk(tag, "strobes", {29'b0, overflow, underflow, pop_valid}, {29'b0, e_ov, e_un, e_pv});
      if (e_pv) chk(tag, "pop_data", pop_data, e_pd);
   endtask

   // Drive at a falling edge, update the model at the rising edge, compare at the next falling edge.
   task automatic step(input bit p, input logic [31:0] d, input bit q, input bit c, input string tag);
      bit fl0, em0;
      push_req = p; push_data = d; pop_req = q; clear = c;
      @(posedge clk);
      fl0 = (mq.size() == DEPTH);
      em0 = (mq.size() == 0);
      if (c) begin
         mq.delete(); e_ov = 0; e_un = 0; e_pv = 0;
      end else begin
         e_ov = p && fl0;
         e_un = q && em0;
         e_pv = q && !em0;
         if (e_pv) e_pd = mq.pop_front();
         if (p && !fl0) mq.push_back(d);
      end
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");                                       // reset state

      for (int i = 0; i < DEPTH; i++) step(1, 32'hA000_0000 + 32'(i), 0, 0, "R3");
      chk("R2", "full at depth", {31'b0, full}, 32'd1);
      step(1, 32'hDEAD_0001, 0, 0, "R6");                   // push on full dropped
      step(0, 0, 0, 0, "R4");                              // quiet cycle holds
      step(1, 32'hDEAD_0002, 1, 0, "R6");                   // push ignored, pop taken
      for (int i = 0; i < DEPTH - 1; i++) step(0, 0, 1, 0, "R5");
      chk("R5", "empty peek marker", peek_data, MARK);
      step(0, 0, 1, 0, "R7");                              // pop on empty
      step(1, 32'h1234_5678, 1, 0, "R7");                   // push accepted, pop dropped
      step(1, 32'h0000_0011, 0, 0, "R3");
      step(1, 32'h0000_0022, 1, 0, "R8");
      step(1, 32'h0000_0033, 1, 0, "R8");
      step(0, 0, 0, 0, "R4");
      step(1, 32'h0000_0044, 0, 0, "R2");
      step(1, 32'h0000_0055, 1, 1, "R9");                   // clear wins
      step(0, 0, 0, 0, "R9");
      step(0, 0, 1, 0, "R7");

      for (int n = 0; n < 600; n++) begin
         logic [31:0] r;
         r = $urandom();
         step(r[0] | r[1], $urandom(), r[2] & r[3] | (r[4] & r[5]), (r[15:8] == 8'h00), "R3");
      end
      for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 1, 0, "R5");
      step(0, 0, 0, 0, "R2");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule